// File: doc/BRIEF.md
# Tiled-Access Channel Address Swizzle

This block sits on the address path of tiled surface accesses in a memory system whose controller alternates consecutive 64-byte blocks between two channels. In that arrangement address bit 6 selects the channel. To keep tiled traffic spread over both channels, the block replaces bit 6 with bit 6 XORed with a chosen set of higher address bits. It leaves every other bit unchanged.

A small configuration register holds one 3-bit swizzle code for X-tiled surfaces and one for Y-tiled surfaces, and it can be read back. Each access carries a 2-bit tiling tag. The tag picks which of the two codes applies, or marks the access as linear, in which case the address passes through untouched. The code value 7 means the real swizzle is not known. The address path treats it exactly like code 0, and a status output raises a flag while either stored code holds that value. A parameter chooses between a purely combinational address path and one with a single register stage.

Top module: `chan_swz_top`

## Requirements
- R1: After reset the configuration readback `cfg_rdata` is 0, so both codes are 0, and `unknown_mode` is 0.
- R2: A write with `cfg_we` high at a rising clock edge stores `cfg_wdata`: bits [2:0] hold the X code and bits [5:3] hold the Y code. `cfg_rdata` shows the stored value from the following cycle on. Without `cfg_we` the stored value is held.
- R3: Every bit of `out_addr` other than bit 6 equals the same bit of the access address.
- R4: A tiling tag of 0 or 3 marks a linear access. Its bit 6 is passed unchanged whatever codes are stored.
- R5: Tag 1 marks an X-tiled access and uses the X code. Tag 2 marks a Y-tiled access and uses the Y code.
- R6: For the code in use, output bit 6 is address bit 6 XORed with the following address bits: code 1 uses bit 9; code 2 uses bits 9 and 10; code 3 uses bits 9 and 11; code 4 uses bits 9, 10 and 11; code 5 uses bits 9 and 17; code 6 uses bits 9, 10 and 17.
- R7: Code 7 leaves bit 6 unchanged. `unknown_mode` is 1 exactly while the stored X code or the stored Y code equals 7.
- R8: With `REGISTERED` = 1, `out_addr` reflects the address, tag and stored codes present at the previous rising edge, and it resets to 0. With `REGISTERED` = 0, `out_addr` follows its inputs in the same cycle.
- R9: Code 0 leaves bit 6 unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Configuration write data: Y code in [5:3], X code in [2:0] |
| cfg_rdata | output | 6 | Stored configuration, same layout as the write data |
| unknown_mode | output | 1 | High while either stored code is 7 |
| req_addr | input | ADDR_W (32) | Access address |
| req_tile | input | 2 | Tiling tag: 0/3 linear, 1 X-tiled, 2 Y-tiled |
| out_addr | output | ADDR_W (32) | Address after the bit-6 correction |

## Verification
The assertions take the tiling tag and address as plain data that may change every cycle. They assume `ADDR_W` is at least 18 so that bit 17 exists. In the registered variant, they compare the output against the inputs held one cycle earlier, and they start doing so only once a full cycle has passed after reset. The stimulus changes inputs only away from the rising edge and holds them across a full cycle before each check. It sweeps every pair of X and Y codes, all four tags, and all 32 combinations of bits 6, 9, 10, 11 and 17 over fixed upper and lower address patterns.

// File: rtl/chan_swz_pkg.sv
package chan_swz_pkg;

    localparam int CODE_W = 3;
    localparam int TILE_W = 2;

    typedef enum logic [CODE_W-1:0] {
        SWZ_NONE      = 3'd0,
        SWZ_B9        = 3'd1,
        SWZ_B9_10     = 3'd2,
        SWZ_B9_11     = 3'd3,
        SWZ_B9_10_11  = 3'd4,
        SWZ_B9_17     = 3'd5,
        SWZ_B9_10_17  = 3'd6,
        SWZ_UNKNOWN   = 3'd7
    } swz_code_e;

    typedef enum logic [TILE_W-1:0] {
        TILE_LINEAR  = 2'd0,
        TILE_X       = 2'd1,
        TILE_Y       = 2'd2,
        TILE_LINEAR2 = 2'd3
    } tile_e;

    typedef struct packed {
        swz_code_e y_code;
        swz_code_e x_code;
    } swz_cfg_t;

    typedef struct packed {
        logic b17;
        logic b11;
        logic b10;
        logic b9;
    } swz_src_t;

    typedef struct packed {
        logic use17;
        logic use11;
        logic use10;
        logic use9;
    } swz_en_t;

endpackage

// File: rtl/swz_cfg_reg.sv
module swz_cfg_reg
    import chan_swz_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     we,
    input  swz_cfg_t wdata,
    output swz_cfg_t cfg,
    output logic     unknown
);

    swz_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{y_code: SWZ_NONE, x_code: SWZ_NONE};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg     = cfg_q;
    assign unknown = (cfg_q.x_code == SWZ_UNKNOWN) || (cfg_q.y_code == SWZ_UNKNOWN);

endmodule

// File: rtl/swz_mode_sel.sv
module swz_mode_sel
    import chan_swz_pkg::*;
(
    input  logic [TILE_W-1:0] tile,
    input  swz_cfg_t          cfg,
    output swz_code_e         code
);

    always_comb begin
        unique case (tile_e'(tile))
            TILE_X:  code = cfg.x_code;
            TILE_Y:  code = cfg.y_code;
            default: code = SWZ_NONE;
        endcase
    end

endmodule

// File: rtl/swz_xor_net.sv
module swz_xor_net
    import chan_swz_pkg::*;
(
    input  swz_code_e code,
    input  swz_src_t  src,
    output logic      flip
);

    swz_en_t en;

    always_comb begin
        en = '0;
        unique case (code)
            SWZ_B9:       en = '{use17: 1'b0, use11: 1'b0, use10: 1'b0, use9: 1'b1};
            SWZ_B9_10:    en = '{use17: 1'b0, use11: 1'b0, use10: 1'b1, use9: 1'b1};
            SWZ_B9_11:    en = '{use17: 1'b0, use11: 1'b1, use10: 1'b0, use9: 1'b1};
            SWZ_B9_10_11: en = '{use17: 1'b0, use11: 1'b1, use10: 1'b1, use9: 1'b1};
            SWZ_B9_17:    en = '{use17: 1'b1, use11: 1'b0, use10: 1'b0, use9: 1'b1};
            SWZ_B9_10_17: en = '{use17: 1'b1, use11: 1'b0, use10: 1'b1, use9: 1'b1};
            default:      en = '0;
        endcase
    end

    assign flip = (en.use9  & src.b9)  ^ (en.use10 & src.b10) ^
                  (en.use11 & src.b11) ^ (en.use17 & src.b17);

endmodule

// File: rtl/chan_swz_top.sv
module chan_swz_top
    import chan_swz_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter bit REGISTERED = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [2*CODE_W-1:0]   cfg_wdata,
    output logic [2*CODE_W-1:0]   cfg_rdata,
    output logic                  unknown_mode,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [TILE_W-1:0]     req_tile,
    output logic [ADDR_W-1:0]     out_addr
);

    localparam int CH_BIT = 6;

    swz_cfg_t  cfg;
    swz_code_e code;
    swz_src_t  src;
    logic      flip;

    initial begin
        if (ADDR_W < 18) $error("ADDR_W must be at least 18");
    end

    swz_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wdata   (swz_cfg_t'(cfg_wdata)),
        .cfg     (cfg),
        .unknown (unknown_mode)
    );

    swz_mode_sel u_sel (
        .tile (req_tile),
        .cfg  (cfg),
        .code (code)
    );

    assign src = '{b17: req_addr[17], b11: req_addr[11], b10: req_addr[10], b9: req_addr[9]};

    swz_xor_net u_net (
        .code (code),
        .src  (src),
        .flip (flip)
    );

    logic [ADDR_W-1:0] addr_d;

    always_comb begin
        addr_d         = req_addr;
        addr_d[CH_BIT] = req_addr[CH_BIT] ^ flip;
    end

    generate
        if (REGISTERED) begin : g_reg
            logic [ADDR_W-1:0] addr_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    addr_q <= '0;
                end else begin
                    addr_q <= addr_d;
                end
            end
            assign out_addr = addr_q;
        end else begin : g_comb
            assign out_addr = addr_d;
        end
    endgenerate

    assign cfg_rdata = cfg;

endmodule

// File: rtl/chan_swz_chk.sv
module chan_swz_chk
    import chan_swz_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter bit REGISTERED = 1'b0
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_we,
    input logic [2*CODE_W-1:0] cfg_wdata,
    input logic [2*CODE_W-1:0] cfg_rdata,
    input logic                unknown_mode,
    input logic [ADDR_W-1:0]   req_addr,
    input logic [TILE_W-1:0]   req_tile,
    input logic [ADDR_W-1:0]   out_addr
);

    logic [ADDR_W-1:0]   ref_addr;
    logic [TILE_W-1:0]   ref_tile;
    logic [2*CODE_W-1:0] ref_cfg;
    logic                ref_ok;

    generate
        if (REGISTERED) begin : g_dly
            logic [ADDR_W-1:0]   addr_q;
            logic [TILE_W-1:0]   tile_q;
            logic [2*CODE_W-1:0] cfg_q;
            logic                ok_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    addr_q <= '0;
                    tile_q <= '0;
                    cfg_q  <= '0;
                    ok_q   <= 1'b0;
                end else begin
                    addr_q <= req_addr;
                    tile_q <= req_tile;
                    cfg_q  <= cfg_rdata;
                    ok_q   <= 1'b1;
                end
            end
            assign ref_addr = addr_q;
            assign ref_tile = tile_q;
            assign ref_cfg  = cfg_q;
            assign ref_ok   = ok_q;
        end else begin : g_now
            assign ref_addr = req_addr;
            assign ref_tile = req_tile;
            assign ref_cfg  = cfg_rdata;
            assign ref_ok   = 1'b1;
        end
    endgenerate

    logic [CODE_W-1:0] ref_code;
    always_comb begin
        case (ref_tile)
            2'd1:    ref_code = ref_cfg[CODE_W-1:0];
            2'd2:    ref_code = ref_cfg[2*CODE_W-1:CODE_W];
            default: ref_code = '0;
        endcase
    end

    assert_bits_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ok |-> (out_addr[ADDR_W-1:7] == ref_addr[ADDR_W-1:7] &&
                    out_addr[5:0] == ref_addr[5:0]));

    assert_no_flip_R4_R7_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_ok && (ref_code == 3'd0 || ref_code == 3'd7)) |-> out_addr[6] == ref_addr[6]);

    assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_rdata == $past(cfg_wdata));

    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_rdata));

    assert_unknown_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_wdata[2:0] == 3'd7 || cfg_wdata[5:3] == 3'd7)) |=> unknown_mode);

    assert_unknown_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[2:0] != 3'd7 && cfg_wdata[5:3] != 3'd7) |=> !unknown_mode);

endmodule

bind chan_swz_top chan_swz_chk #(.ADDR_W(ADDR_W), .REGISTERED(REGISTERED)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .unknown_mode (unknown_mode),
    .req_addr     (req_addr),
    .req_tile     (req_tile),
    .out_addr     (out_addr)
);

// File: tb/sim_chan_swz_top.sv
module sim_chan_swz_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [5:0]    cfg_wdata = '0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_tile = '0;
    logic [5:0]    rd0, rd1;
    logic          unk0, unk1;
    logic [AW-1:0] out0, out1;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_swz_top #(.ADDR_W(AW), .REGISTERED(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rd0), .unknown_mode(unk0), .req_addr(req_addr),
        .req_tile(req_tile), .out_addr(out0));

    chan_swz_top #(.ADDR_W(AW), .REGISTERED(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rd1), .unknown_mode(unk1), .req_addr(req_addr),
        .req_tile(req_tile), .out_addr(out1));

    function automatic logic flip_of(input logic [2:0] c, input logic [AW-1:0] a);
        case (c)
            3'd1: return a[9];
            3'd2: return a[9] ^ a[10];
            3'd3: return a[9] ^ a[11];
            3'd4: return a[9] ^ a[10] ^ a[11];
            3'd5: return a[9] ^ a[17];
            3'd6: return a[9] ^ a[10] ^ a[17];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [AW-1:0] expect_addr(input logic [5:0] cfg,
                                                   input logic [1:0] t,
                                                   input logic [AW-1:0] a);
        logic [2:0] c;
        logic [AW-1:0] r;
        c = (t == 2'd1) ? cfg[2:0] : (t == 2'd2) ? cfg[5:3] : 3'd0;
        r = a;
        r[6] = a[6] ^ flip_of(c, a);
        return r;
    endfunction

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [5:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [AW-1:0] make_addr(input int k, input logic [AW-1:0] base);
        logic [AW-1:0] a;
        a = base;
        a[6] = k[0]; a[9] = k[1]; a[10] = k[2]; a[11] = k[3]; a[17] = k[4];
        return a;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [5:0] cfg;
        logic [AW-1:0] a;
        repeat (3) @(negedge clk);
        req_addr = 32'hFFFF_FFFF;
        req_tile = 2'd1;
        @(negedge clk);
        // R1: reset state
        check("R1 cfg", {26'd0, rd0}, '0);
        check("R1 unknown", {31'd0, unk0}, '0);
        check("R8 reset out", out1, '0);
        rst_n = 1'b1;

        // R2: readback and hold
        write_cfg(6'b101_011);
        check("R2 readback", {26'd0, rd0}, {26'd0, 6'b101_011});
        @(negedge clk);
        check("R2 hold", {26'd0, rd0}, {26'd0, 6'b101_011});

        // R7: unknown flag
        write_cfg(6'b000_111);
        check("R7 flag x", {31'd0, unk0}, 32'd1);
        write_cfg(6'b111_000);
        check("R7 flag y", {31'd0, unk0}, 32'd1);
        write_cfg(6'b110_001);
        check("R7 flag clear", {31'd0, unk0}, 32'd0);

        // R3 R4 R5 R6 R7 R9: full sweep of code pairs, tags and source bits
        for (int xc = 0; xc < 8; xc++) begin
            for (int yc = 0; yc < 8; yc++) begin
                cfg = {yc[2:0], xc[2:0]};
                write_cfg(cfg);
                for (int t = 0; t < 4; t++) begin
                    for (int k = 0; k < 32; k++) begin
                        a = make_addr(k, (k % 2 == 0) ? 32'hA5C3_0F3C : 32'h5A3C_F0C3);
                        @(negedge clk);
                        req_addr = a;
                        req_tile = t[1:0];
                        #1;
                        check("R3 R4 R5 R6 R7 R9 comb", out0, expect_addr(cfg, t[1:0], a));
                        @(posedge clk);
                        #1;
                        check("R8 registered", out1, expect_addr(cfg, t[1:0], a));
                    end
                end
            end
        end

        // R8: registered output lags by one edge
        write_cfg(6'b000_001);
        @(negedge clk);
        req_addr = 32'h0000_0200;
        req_tile = 2'd1;
        @(posedge clk);
        #1;
        check("R8 after edge", out1, 32'h0000_0240);
        @(negedge clk);
        req_addr = 32'h0000_0000;
        #1;
        check("R8 held before edge", out1, 32'h0000_0240);
        check("R8 comb immediate", out0, 32'h0000_0000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule